// File: doc/BRIEF.md
# Flash Status Register Write Guard

This block decides whether each command that reaches a serial flash device may change the device's status register or its memory array. It keeps the status register (a lock bit, a region-select bit and a four-bit guard level) and a write latch. It also watches a write-protect pin. Decoded commands arrive one per cycle with a target address and, for status writes, a data byte. One cycle later the block reports whether it accepted the command and updates its register and latch.

Three things decide the status register lock: the lock bit, the synchronized level of the pin, and the write latch. With the lock bit set and the pin low the register is frozen. The lock takes hold whichever of the two conditions is met first, and only a high pin releases it. The guard level selects a power-of-two run of 64 KB sectors at the top or the bottom of a 16 MB array. Programs and erases that land in that run are refused. A whole-array erase is refused whenever any guard is set.

Top module: `flash_guard`

## Requirements
- R1: After reset `status_o` is 0x00, `wr_latch_o`, `resp_valid_o` and `locked_o` are 0. Command codes on `cmd_op_i` are 1 latch-set, 2 latch-clear, 3 status write, 4 page program, 5 sector erase and 6 whole-array erase. `status_o` reads {lock, region-select, level[3:0], latch, 0} from bit 7 down to bit 0, and a status write takes bits 7:2 of `cmd_data_i` into the same positions.
- R2: Latch-set and latch-clear are always accepted. They set and clear the latch respectively, also while the register is locked.
- R3: With the lock bit 0, a status write is accepted exactly when the latch is set, whatever the pin level.
- R4: With the lock bit 1 and the pin high, a status write is accepted exactly when the latch is set.
- R5: With the lock bit 1 and the synchronized pin low, every status write is rejected and status bits 7:2 do not change.
- R6: `locked_o` rises when the lock bit is set while the pin is low, and also when the pin falls while the lock bit is set. It falls only after the pin goes high. The pin is seen through a two-stage synchronizer, and `locked_o` follows it by one more register.
- R7: A page program or sector erase needs the latch set. It is rejected when its sector, `cmd_addr_i[23:16]`, lies in the guarded run, and accepted otherwise.
- R8: Guard level n = 0 guards nothing. For n from 1 to 8 it guards 2^(n-1) sectors, and from 9 up it guards all 256. Region-select 0 counts the run from sector 255 downward, and 1 counts it from sector 0 upward.
- R9: A whole-array erase is accepted only when the latch is set and the guard level is 0.
- R10: An accepted status write, program or erase clears the latch. A rejected command leaves the latch unchanged.
- R11: `resp_valid_o` is high in exactly the cycle after each cycle with `cmd_valid_i` high, and `resp_accept_o` gives that command's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_pin_i | input | 1 | Write-protect pin, low asserts protection (asynchronous) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | 24 | Byte address for program and erase |
| cmd_data_i | input | 8 | New status value for a status write |
| resp_valid_o | output | 1 | Verdict strobe, one cycle after the command |
| resp_accept_o | output | 1 | 1 when the command was accepted |
| status_o | output | 8 | Status register with the latch in bit 1 |
| wr_latch_o | output | 1 | Write latch |
| locked_o | output | 1 | Status register frozen by the pin |

## Verification
A pin change and a status write can fall in the same cycle: the synchronizer output flips at the same edge that judges the write. The bench raises the pin, lets exactly one clock edge pass, and then issues a status write. That write must be judged on the old, low pin level and rejected. An identical write one cycle later must be accepted. The bench also drives both orders of pin and lock bit to enter the locked state, and checks the release and re-entry.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_WR_EN      = 3'd1,
    OP_WR_DIS     = 3'd2,
    OP_STAT_WR    = 3'd3,
    OP_PAGE_PROG  = 3'd4,
    OP_SECT_ERASE = 3'd5,
    OP_CHIP_ERASE = 3'd6
  } fg_op_e;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fg_region.sv
module fg_region #(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic [ADDR_W-SECT_W-1:0] sector,
  input  logic [LVL_W-1:0]         level,
  input  logic                     from_bottom,
  output logic                     hit
);
  localparam int NSECT_W = ADDR_W - SECT_W;
  localparam int CNT_W   = NSECT_W + 1;
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(1) << NSECT_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] sect_w;

  always_comb begin
    count = '0;
    if (level != '0) begin
      if (int'(level) - 1 >= NSECT_W) count = TOTAL;
      else                           count = CNT_W'(1) << (int'(level) - 1);
    end
  end

  assign sect_w = {1'b0, sector};

  always_comb begin
    if (count == '0)      hit = 1'b0;
    else if (from_bottom) hit = sect_w < count;
    else                  hit = sect_w >= (TOTAL - count);
  end
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import fg_pkg::*;
(
  input  fg_op_e op,
  input  logic   wr_latch,
  input  logic   lock_bit,
  input  logic   pin_hi,
  input  logic   region_hit,
  input  logic   any_guard,
  output logic   ok
);
  always_comb begin
    unique case (op)
      OP_WR_EN, OP_WR_DIS:         ok = 1'b1;
      OP_STAT_WR:                  ok = wr_latch && !(lock_bit && !pin_hi);
      OP_PAGE_PROG, OP_SECT_ERASE: ok = wr_latch && !region_hit;
      OP_CHIP_ERASE:               ok = wr_latch && !any_guard;
      default:                     ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 16,
  parameter int LVL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_pin_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  output logic              resp_valid_o,
  output logic              resp_accept_o,
  output logic [7:0]        status_o,
  output logic              wr_latch_o,
  output logic              locked_o
);
  localparam int LVL_LO = 2;
  localparam int LVL_HI = LVL_LO + LVL_W - 1;

  fg_op_e           op;
  logic             pin_hi;
  logic             lock_bit, from_bottom, wr_latch, locked_q;
  logic [LVL_W-1:0] guard_lvl;
  logic             region_hit, ok;
  logic             unused_bits;

  assign op          = fg_op_e'(cmd_op_i);
  assign unused_bits = ^{cmd_addr_i[SECT_W-1:0], cmd_data_i[1:0]};

  fg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(prot_pin_i), .q(pin_hi)
  );

  fg_region #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .LVL_W(LVL_W)) u_region (
    .sector(cmd_addr_i[ADDR_W-1:SECT_W]), .level(guard_lvl),
    .from_bottom(from_bottom), .hit(region_hit)
  );

  fg_decide u_decide (
    .op(op), .wr_latch(wr_latch), .lock_bit(lock_bit), .pin_hi(pin_hi),
    .region_hit(region_hit), .any_guard(guard_lvl != '0), .ok(ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_bit      <= 1'b0;
      from_bottom   <= 1'b0;
      guard_lvl     <= '0;
      wr_latch      <= 1'b0;
      resp_valid_o  <= 1'b0;
      resp_accept_o <= 1'b0;
      locked_q      <= 1'b0;
    end else begin
      resp_valid_o  <= cmd_valid_i;
      resp_accept_o <= cmd_valid_i && ok;
      locked_q      <= lock_bit && !pin_hi;
      if (cmd_valid_i && ok) begin
        unique case (op)
          OP_WR_EN:  wr_latch <= 1'b1;
          OP_WR_DIS: wr_latch <= 1'b0;
          OP_STAT_WR: begin
            lock_bit    <= cmd_data_i[7];
            from_bottom <= cmd_data_i[6];
            guard_lvl   <= cmd_data_i[LVL_HI:LVL_LO];
            wr_latch    <= 1'b0;
          end
          default:   wr_latch <= 1'b0;
        endcase
      end
    end
  end

  assign status_o   = {lock_bit, from_bottom, guard_lvl, wr_latch, 1'b0};
  assign wr_latch_o = wr_latch;
  assign locked_o   = locked_q;

  // R2: latch-set always lands
  a_r2_latch_set: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && op == OP_WR_EN) |=> wr_latch_o);

  // R5: frozen register rejects status writes
  a_r5_reject_locked: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && op == OP_STAT_WR && lock_bit && !pin_hi) |=> !resp_accept_o);

  // R5: protection bits hold while frozen
  a_r5_bits_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_bit && !pin_hi) |=> $stable(status_o[7:2]));

  // R6: locked indication implies the lock bit
  a_r6_lock_bit: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> status_o[7]);

  // R9: whole-array erase refused under any guard
  a_r9_chip_erase: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && op == OP_CHIP_ERASE && guard_lvl != '0) |=> !resp_accept_o);

  // R10: accepted modifying command clears the latch
  a_r10_latch_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && ok && op inside {OP_STAT_WR, OP_PAGE_PROG, OP_SECT_ERASE, OP_CHIP_ERASE})
    |=> !wr_latch_o);

  // R11: one verdict per command, one cycle later
  a_r11_resp: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i |=> resp_valid_o);
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_i |=> !resp_valid_o);
endmodule

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b1;
  logic        cvalid = 1'b0;
  logic [2:0]  cop = 3'd0;
  logic [23:0] caddr = '0;
  logic [7:0]  cdata = '0;
  logic        rvalid, raccept, latch, locked;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst(rst), .prot_pin_i(pin), .cmd_valid_i(cvalid),
    .cmd_op_i(cop), .cmd_addr_i(caddr), .cmd_data_i(cdata),
    .resp_valid_o(rvalid), .resp_accept_o(raccept), .status_o(status),
    .wr_latch_o(latch), .locked_o(locked)
  );

  // {req[3:0], pin, op[2:0], addr[23:0], data[7:0], accept, status[7:0]}
  localparam int NV = 37;
  localparam logic [48:0] VEC [NV] = '{
    {4'd3, 1'b1, 3'd3, 24'h000000, 8'h80, 1'b0, 8'h00}, // R3 no latch, pin high
    {4'd3, 1'b0, 3'd3, 24'h000000, 8'h80, 1'b0, 8'h00}, // R3 no latch, pin low
    {4'd2, 1'b0, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h02}, // R2
    {4'd3, 1'b0, 3'd3, 24'h000000, 8'h14, 1'b1, 8'h14}, // R3 pin low ignored
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h16}, // R2
    {4'd10,1'b1, 3'd4, 24'hF00000, 8'h00, 1'b0, 8'h16}, // R10 R7 top run hit
    {4'd7, 1'b1, 3'd4, 24'hEFFFFF, 8'h00, 1'b1, 8'h14}, // R7 just below run
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h16}, // R2
    {4'd9, 1'b1, 3'd6, 24'h000000, 8'h00, 1'b0, 8'h16}, // R9 guard set
    {4'd7, 1'b1, 3'd5, 24'h000000, 8'h00, 1'b1, 8'h14}, // R7 sector 0 free
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h16}, // R2
    {4'd2, 1'b1, 3'd2, 24'h000000, 8'h00, 1'b1, 8'h14}, // R2 clear
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h16}, // R2
    {4'd3, 1'b1, 3'd3, 24'h000000, 8'hC0, 1'b1, 8'hC0}, // R3 set lock
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'hC2}, // R2
    {4'd4, 1'b1, 3'd3, 24'h000000, 8'hC4, 1'b1, 8'hC4}, // R4 lock, pin high
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'hC6}, // R2
    {4'd5, 1'b0, 3'd3, 24'h000000, 8'h00, 1'b0, 8'hC6}, // R5 frozen
    {4'd7, 1'b0, 3'd5, 24'h000000, 8'h00, 1'b0, 8'hC6}, // R7 bottom sector 0
    {4'd7, 1'b0, 3'd4, 24'h010000, 8'h00, 1'b1, 8'hC4}, // R7 sector 1 free
    {4'd2, 1'b0, 3'd1, 24'h000000, 8'h00, 1'b1, 8'hC6}, // R2 while frozen
    {4'd6, 1'b1, 3'd3, 24'h000000, 8'h00, 1'b1, 8'h00}, // R6 pin high releases
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h02},
    {4'd8, 1'b1, 3'd3, 24'h000000, 8'h24, 1'b1, 8'h24}, // R8 level 9
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h26},
    {4'd8, 1'b1, 3'd4, 24'h000000, 8'h00, 1'b0, 8'h26}, // R8 whole array
    {4'd8, 1'b1, 3'd3, 24'h000000, 8'h38, 1'b1, 8'h38}, // R8 level 14
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h3A},
    {4'd8, 1'b1, 3'd4, 24'hFFFFFF, 8'h00, 1'b0, 8'h3A}, // R8 top sector
    {4'd8, 1'b1, 3'd3, 24'h000000, 8'h00, 1'b1, 8'h00}, // R8 level 0
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h02},
    {4'd9, 1'b1, 3'd6, 24'h000000, 8'h00, 1'b1, 8'h00}, // R9 no guard
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h02},
    {4'd8, 1'b1, 3'd3, 24'h000000, 8'h50, 1'b1, 8'h50}, // R8 bottom, level 4
    {4'd2, 1'b1, 3'd1, 24'h000000, 8'h00, 1'b1, 8'h52},
    {4'd8, 1'b1, 3'd4, 24'h07FFFF, 8'h00, 1'b0, 8'h52}, // R8 sector 7 guarded
    {4'd8, 1'b1, 3'd4, 24'h080000, 8'h00, 1'b1, 8'h50}  // R8 sector 8 free
  };

  task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  // caller sits at a falling edge
  task automatic do_cmd(input logic [2:0] op, input logic [23:0] a, input logic [7:0] d);
    cvalid = 1'b1; cop = op; caddr = a; cdata = d;
    @(posedge clk);
    @(negedge clk);
    cvalid = 1'b0; cop = 3'd0;
  endtask

  task automatic set_pin(input logic v);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(1, {5'd0, rvalid, latch, locked, status}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (pin !== VEC[i][44]) set_pin(VEC[i][44]);
      do_cmd(VEC[i][43:41], VEC[i][40:17], VEC[i][16:9]);
      check(int'(VEC[i][48:45]), {6'd0, rvalid, raccept, status},
            {6'd0, 1'b1, VEC[i][8], VEC[i][7:0]});
    end

    // R11 no verdict without a command
    @(negedge clk);
    check(11, {15'd0, rvalid}, 16'h0000);

    // R6 lock bit first, then pin low
    do_cmd(3'd1, 24'h0, 8'h00);
    do_cmd(3'd3, 24'h0, 8'h80);
    check(6, {8'd0, status}, 16'h0080);
    check(6, {15'd0, locked}, 16'h0000);
    set_pin(1'b0);
    check(6, {15'd0, locked}, 16'h0001);
    set_pin(1'b1);
    check(6, {15'd0, locked}, 16'h0000);

    // R6 pin low first, then lock bit
    do_cmd(3'd1, 24'h0, 8'h00);
    do_cmd(3'd3, 24'h0, 8'h00);
    set_pin(1'b0);
    check(6, {15'd0, locked}, 16'h0000);
    do_cmd(3'd1, 24'h0, 8'h00);
    do_cmd(3'd3, 24'h0, 8'h80);
    check(3, {7'd0, raccept, status}, 16'h0180);
    repeat (2) @(negedge clk);
    check(6, {15'd0, locked}, 16'h0001);

    // R5 latch set but frozen
    do_cmd(3'd1, 24'h0, 8'h00);
    do_cmd(3'd3, 24'h0, 8'h00);
    check(5, {7'd0, raccept, status}, 16'h0082);

    // R6 pin rises, write lands on the edge where the synchronizer still shows low
    pin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    do_cmd(3'd3, 24'h0, 8'h00);
    check(5, {7'd0, raccept, status}, 16'h0082);
    do_cmd(3'd3, 24'h0, 8'h00);
    check(4, {7'd0, raccept, status}, 16'h0100);
    @(negedge clk);
    check(6, {15'd0, locked}, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule